// File: doc/BRIEF.md
# Two-Key Register Write Unlock Gate

This block sits between a bus write port and a protected register file and decides whether each write may reach it. After reset it is locked and every write aimed at a protected address is dropped. Two dedicated kick registers sit at fixed byte offsets. Software opens the gate by writing a first 32-bit key into the first kick register and then a second, different key into the second one. Writing any other value into either kick register, zero included, closes the gate at once.

The protected register file takes the bus address and data directly. Only its write enable comes from this gate. Reads never pass through the gate and are never blocked. A status output reports whether the gate is currently open, so that software and tests can check it.

Top module: `ulk_gate`

## Requirements
- R1: After reset the gate is closed (`unlocked` = 0), and the first key is counted as not yet written.
- R2: A write of 0x83E70B13 to the first kick register (byte offset 0x6C), followed later by a write of 0x95A4F1E0 to the second kick register (byte offset 0x70), opens the gate. `unlocked` is 1 from the clock edge that takes the second write. Writes to other addresses between the two keys do not prevent the unlock.
- R3: A correct second key that arrives while the first key is not held (for example, with the two keys written in reverse order) leaves the gate closed.
- R4: A write of any value other than 0x83E70B13 to offset 0x6C closes the gate and discards the held first key, starting at the next edge.
- R5: A write of any value other than 0x95A4F1E0 to offset 0x70 closes the gate, starting at the next edge. Writing zero to both kick registers leaves the gate closed.
- R6: While the gate is closed, `prot_wr_en` stays 0 for writes to every address.
- R7: While the gate is open, a write to any address other than the two kick offsets raises `prot_wr_en` in the same cycle. With no write in progress, `prot_wr_en` is 0.
- R8: Writes to either kick offset never raise `prot_wr_en`.
- R9: The lock state changes only on writes to a kick offset. Any number of protected writes leaves it unchanged.
- R10: Writing the correct first key again while the gate is open keeps the gate open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | DATA_W (32) | Write data |
| prot_wr_en | output | 1 | Filtered write enable to the protected register file |
| unlocked | output | 1 | Current lock state, 1 = open |

## Verification
The main unlock function is exercised with several key patterns:
- The proper order.
- The reverse order.
- Proper order with unrelated writes between the keys.
- A wrong first key.
- A wrong second key.
- A correct first key followed by a corrupting first-kick write.
- The zero/zero relock.

Together these show whether the gate tracks the held first key, rather than simply responding to the most recent kick write. Protected writes are issued both while closed and while open, and kick writes while open. This separates the combinational gating from the lock state and confirms that kick registers are never forwarded to the register file.

// File: rtl/ulk_pkg.sv
package ulk_pkg;

  localparam logic [31:0] ULK_KEY_A = 32'h83E7_0B13;
  localparam logic [31:0] ULK_KEY_B = 32'h95A4_F1E0;
  localparam logic [7:0]  ULK_OFS_A = 8'h6C;
  localparam logic [7:0]  ULK_OFS_B = 8'h70;

  // One decoded bus write, classified.
  typedef struct packed {
    logic a_good;   // key A written to kick A
    logic a_bad;    // other value written to kick A
    logic b_good;   // key B written to kick B
    logic b_bad;    // other value written to kick B
    logic plain;    // write to a non-kick address
  } ulk_evt_t;

  function automatic logic ulk_word_eq(input logic [31:0] a, input logic [31:0] b);
    return (a ^ b) == 32'd0;
  endfunction

endpackage

// File: rtl/ulk_decode.sv
module ulk_decode
  import ulk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_A = ADDR_W'(ULK_OFS_A),
  parameter logic [ADDR_W-1:0] OFS_B = ADDR_W'(ULK_OFS_B),
  parameter logic [DATA_W-1:0] KEY_A = DATA_W'(ULK_KEY_A),
  parameter logic [DATA_W-1:0] KEY_B = DATA_W'(ULK_KEY_B)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ulk_evt_t          evt
);
  localparam int PAD = (DATA_W < 32) ? 32 - DATA_W : 0;

  logic hit_a, hit_b, val_a, val_b;

  assign hit_a = wr_en && (wr_addr == OFS_A);
  assign hit_b = wr_en && (wr_addr == OFS_B);
  assign val_a = ulk_word_eq(32'({{PAD{1'b0}}, wr_data}), 32'({{PAD{1'b0}}, KEY_A}));
  assign val_b = ulk_word_eq(32'({{PAD{1'b0}}, wr_data}), 32'({{PAD{1'b0}}, KEY_B}));

  always_comb begin
    evt.a_good = hit_a &&  val_a;
    evt.a_bad  = hit_a && !val_a;
    evt.b_good = hit_b &&  val_b;
    evt.b_bad  = hit_b && !val_b;
    evt.plain  = wr_en && !hit_a && !hit_b;
  end

endmodule

// File: rtl/ulk_state.sv
module ulk_state
  import ulk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ulk_evt_t evt,
  output logic     armed,
  output logic     open_q
);
  logic relock;
  assign relock = evt.a_bad || evt.b_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      open_q <= 1'b0;
    end else begin
      if (evt.a_good)     armed <= 1'b1;
      else if (evt.a_bad) armed <= 1'b0;
      if (relock)                       open_q <= 1'b0;
      else if (evt.b_good && armed)     open_q <= 1'b1;
    end
  end

  // R2: opening only follows a key B write with key A held
  a_r2_open_needs_keys: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(evt.b_good && armed));
  // R3: key B without key A held keeps the gate closed
  a_r3_no_open_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.b_good && !armed) |=> !open_q);
  // R4: bad kick A closes and disarms
  a_r4_bad_a_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    evt.a_bad |=> (!open_q && !armed));
  // R5: bad kick B closes
  a_r5_bad_b_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    evt.b_bad |=> !open_q);
  // R10: open gate implies key A still held
  a_r10_open_implies_armed: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> armed);

endmodule

// File: rtl/ulk_gate.sv
module ulk_gate
  import ulk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_A = ADDR_W'(ULK_OFS_A),
  parameter logic [ADDR_W-1:0] OFS_B = ADDR_W'(ULK_OFS_B),
  parameter logic [DATA_W-1:0] KEY_A = DATA_W'(ULK_KEY_A),
  parameter logic [DATA_W-1:0] KEY_B = DATA_W'(ULK_KEY_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prot_wr_en,
  output logic              unlocked
);
  ulk_evt_t evt;
  logic     armed;
  logic     open_q;
  logic     kick_wr;

  ulk_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_A(OFS_A), .OFS_B(OFS_B), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .evt(evt)
  );

  ulk_state u_state (
    .clk(clk), .rst_n(rst_n), .evt(evt), .armed(armed), .open_q(open_q)
  );

  assign kick_wr    = evt.a_good || evt.a_bad || evt.b_good || evt.b_bad;
  assign prot_wr_en = evt.plain && open_q;
  assign unlocked   = open_q;

  // R6: closed gate never forwards
  a_r6_closed_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !prot_wr_en);
  // R8: kick writes are never forwarded
  a_r8_kick_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == OFS_A || wr_addr == OFS_B)) |-> !prot_wr_en);
  // R7: no bus write, no enable
  a_r7_no_write_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !prot_wr_en);
  // R9: lock state moves only on kick writes
  a_r9_stable_without_kick: assert property (@(posedge clk) disable iff (!rst_n)
    !kick_wr |=> $stable(unlocked));

endmodule

// File: tb/test_ulk_gate.sv
module test_ulk_gate;
  localparam logic [7:0]  OA = 8'h6C;
  localparam logic [7:0]  OB = 8'h70;
  localparam logic [31:0] KA = 32'h83E70B13;
  localparam logic [31:0] KB = 32'h95A4F1E0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic prot_wr_en, unlocked;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ulk_gate i_ulk_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prot_wr_en(prot_wr_en), .unlocked(unlocked)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one write cycle; returns the gate enable seen during it
  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic seen);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1 seen = prot_wr_en;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic s;
    do_reset();
    chk("R1 locked after reset", unlocked, 1'b0);
    // key B alone must not open: first key not held after reset
    wr(OB, KB, s);
    chk("R1 first key not held after reset", unlocked, 1'b0);
  endtask

  task automatic t_unlock();
    logic s;
    do_reset();
    wr(OA, KA, s);
    chk("R2 still locked after key A only", unlocked, 1'b0);
    wr(OB, KB, s);
    chk("R2 unlocked after A then B", unlocked, 1'b1);
  endtask

  task automatic t_unlock_interleaved();
    logic s;
    do_reset();
    wr(OA, KA, s);
    wr(8'h10, 32'h1234, s);
    chk("R6 protected write blocked while locked", s, 1'b0);
    wr(OB, KB, s);
    chk("R2 unlock with writes between keys", unlocked, 1'b1);
  endtask

  task automatic t_reverse();
    logic s;
    do_reset();
    wr(OB, KB, s);
    wr(OA, KA, s);
    chk("R3 reverse order stays locked", unlocked, 1'b0);
  endtask

  task automatic t_bad_a();
    logic s;
    do_reset();
    wr(OA, 32'h83E70B12, s);
    wr(OB, KB, s);
    chk("R4 wrong key A gives no unlock", unlocked, 1'b0);
    // held key A discarded by a bad kick A write
    wr(OA, KA, s);
    wr(OA, 32'h0, s);
    wr(OB, KB, s);
    chk("R4 bad kick A discards held key", unlocked, 1'b0);
    // relock from open state
    wr(OA, KA, s);
    wr(OB, KB, s);
    chk("R2 reopen", unlocked, 1'b1);
    wr(OA, 32'hFFFF_FFFF, s);
    chk("R4 bad kick A relocks", unlocked, 1'b0);
  endtask

  task automatic t_bad_b();
    logic s;
    do_reset();
    wr(OA, KA, s);
    wr(OB, KB, s);
    wr(OB, 32'h95A4F1E1, s);
    chk("R5 bad kick B relocks", unlocked, 1'b0);
    wr(OB, KB, s);
    chk("R5 kick A still held after bad B", unlocked, 1'b1);
    wr(OA, 32'h0, s);
    wr(OB, 32'h0, s);
    chk("R5 zero-zero relock", unlocked, 1'b0);
    wr(8'h40, 32'h5, s);
    chk("R6 blocked after relock", s, 1'b0);
  endtask

  task automatic t_forward();
    logic s;
    do_reset();
    wr(OA, KA, s);
    chk("R8 kick A write not forwarded", s, 1'b0);
    wr(OB, KB, s);
    chk("R8 kick B write not forwarded", s, 1'b0);
    for (int i = 0; i < 8; i++) begin
      wr(8'(i * 4), 32'(i), s);
      chk("R7 protected write forwarded while open", s, 1'b1);
    end
    chk("R9 still open after protected writes", unlocked, 1'b1);
    @(negedge clk); #1;
    chk("R7 no enable without write", prot_wr_en, 1'b0);
    wr(OA, KA, s);
    chk("R8 kick A write not forwarded while open", s, 1'b0);
    chk("R10 key A rewrite keeps open", unlocked, 1'b1);
    wr(OB, KB, s);
    chk("R8 kick B write not forwarded while open", s, 1'b0);
    chk("R10 key B rewrite keeps open", unlocked, 1'b1);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_unlock();
    t_unlock_interleaved();
    t_reverse();
    t_bad_a();
    t_bad_b();
    t_forward();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule